// File: doc/BRIEF.md
# Read Completion Coalescer

This block sits on the root-complex side of a serial point-to-point link, between the memory side that returns read data one 64-byte cache line at a time and the transmit path toward the requesting device. Each returned line comes with the tag of its read request, its cache-line address, the first valid byte inside the line, the number of valid bytes, the bytes of the request still outstanding, and a flag that marks the request's final line. The block turns these lines into read completion packets. Each packet is a header (tag, payload length, remaining byte count, lower address) followed by the payload as one beat per line.

When merging is off, every line leaves as its own completion. When merging is on, consecutive lines of one request are held in a local store and merged into one completion. The group closes when the request ends, when the next line breaks the run, when the configured payload cap is reached, or when the store is full. A closed completion leaves only once the internal credit pool covers its header and data cost. While a completion waits or is sent, no new line is taken.

Top module: `rcc_coalescer`

## Requirements
- R1: After reset no completion beat is presented, `line_ready` is high and the credit pool is empty.
- R2: With `comb_en` low, every accepted line produces one completion of exactly one beat whose length equals that line's valid byte count.
- R3: With `comb_en` high, contiguous lines of one tag (same tag, line address one higher than the previous line) are held and sent as one completion whose length is the sum of their valid bytes. The group closes on the line flagged `line_last`.
- R4: The payload cap in bytes is 128 shifted left by `mps_sel`, so 0..5 select 128..4096, and codes 6 and 7 select 4096. A line that would push the held byte total above the cap closes the group first. A group that reaches the cap exactly, or that fills all store slots, closes at once.
- R5: A request of at most 64 bytes that starts in one line and ends in the next is sent as a single two-beat completion when merging is on.
- R6: A line with another tag, or with a line address that does not follow the held group, closes the held group. That line is not taken until the held completion has gone, and it then starts a new group.
- R7: A completion carries the tag of its lines. Its byte count is the remaining-bytes value of its first line. Its 7-bit lower address is {first line address bit 0, first valid byte offset}.
- R8: A completion costs 1 + ceil(length/16) credits. The pool gains `credit_ret` every cycle and saturates at its maximum. A completion starts only when the pool holds at least its cost, and the cost is removed when it starts.
- R9: Payload beats are presented on consecutive cycles, in line arrival order, with `cpl_sop` on the first beat and `cpl_eop` on the last.
- R10: `line_ready` is low from the cycle a group closes until the last beat of its completion has been presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comb_en | input | 1 | Merge consecutive lines when high |
| mps_sel | input | 3 | Payload cap select |
| credit_ret | input | CRED_W | Credits returned this cycle |
| line_valid | input | 1 | A returned line is offered |
| line_ready | output | 1 | The offered line is taken this cycle |
| line_tag | input | TAG_W | Request tag of the line |
| line_addr | input | LADDR_W | Cache-line address |
| line_lo | input | 6 | First valid byte inside the line |
| line_bytes | input | 7 | Valid bytes in the line, 1..64 |
| line_remain | input | 13 | Request bytes outstanding, this line included |
| line_last | input | 1 | Final line of the request |
| line_data | input | 512 | Line contents |
| cpl_valid | output | 1 | Completion beat valid |
| cpl_sop | output | 1 | First beat of a completion |
| cpl_eop | output | 1 | Last beat of a completion |
| cpl_tag | output | TAG_W | Completion tag |
| cpl_len | output | 13 | Payload length in bytes |
| cpl_byte_count | output | 13 | Remaining byte count |
| cpl_lower_addr | output | 7 | Lower address of first payload byte |
| cpl_data | output | 512 | Payload beat, one line |

## Verification
The bench builds the block with its default parameters: a 64-slot line store, a 12-bit credit pool, 8-bit tags and 26-bit line addresses. With 64 slots, a full 4096-byte completion fits, so the clamp of the unused cap codes to 4096 can be reached, and so can the close on a full cap followed by a single trailing line. Because the pool starts empty after reset, the stall of a ready completion can be observed one credit short of its cost before the bench switches to a steady credit return.

// File: rtl/rcc_pkg.sv
// Package: shared constants, state type and helpers of the completion coalescer.
// Assumes 64-byte cache lines and a 4096-byte largest payload.
package rcc_pkg;
    localparam int LINE_BYTES = 64;
    localparam int LEN_W      = 13;
    localparam int LOW_W      = 7;
    localparam int COST_W     = 10;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_WAIT    = 2'd1,
        ST_SEND    = 2'd2
    } rcc_state_e;

    // Payload cap in bytes for a select code; codes above 5 clamp to 4096.
    function automatic logic [LEN_W-1:0] cap_bytes(input logic [2:0] sel);
        logic [2:0] s;
        s = (sel > 3'd5) ? 3'd5 : sel;
        return LEN_W'(128) << s;
    endfunction

    // Credit cost: one header credit plus one data credit per 16 bytes.
    function automatic logic [COST_W-1:0] cpl_cost(input logic [LEN_W-1:0] len);
        return COST_W'(len[LEN_W-1:4]) + COST_W'(len[3:0] != 4'd0) + COST_W'(1);
    endfunction
endpackage

// File: rtl/rcc_line_store.sv
// Line store: holds the lines of the group being formed, one slot per line.
// Assumes DEPTH is a power of two; write and read never target the same
// slot in one cycle because the controller only reads while sending.
module rcc_line_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 512,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_data [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        // Capture the incoming line when this slot is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) slot_q <= wr_data;
        end
        assign slot_data[g] = slot_q;
    end

    assign rd_data = slot_data[rd_idx];
endmodule

// File: rtl/rcc_credit_pool.sv
// Credit pool: accumulates returned credits with saturation and removes the
// cost of each completion when it starts. Empty after reset.
// Assumes CRED_W is wider than the largest cost.
module rcc_credit_pool #(
    parameter int CRED_W = 12,
    parameter int COST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CRED_W-1:0] ret,
    input  logic              take,
    input  logic [COST_W-1:0] cost,
    output logic              enough
);
    logic [CRED_W-1:0] pool_q;
    logic [CRED_W:0]   sum_w;
    logic [CRED_W:0]   after_w;

    // Next pool value: add returns, remove the cost being spent, saturate.
    always_comb begin
        sum_w   = {1'b0, pool_q} + {1'b0, ret};
        after_w = sum_w - (take ? (CRED_W+1)'(cost) : '0);
    end

    // Pool register.
    always_ff @(posedge clk) begin
        if (!rst_n)              pool_q <= '0;
        else if (after_w[CRED_W]) pool_q <= '1;
        else                     pool_q <= after_w[CRED_W-1:0];
    end

    assign enough = (pool_q >= CRED_W'(cost));

    // Spending is only allowed with a covered cost.
    assert_take_covered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (pool_q >= CRED_W'(cost)));
    // Without a spend the pool can only grow or hold.
    assert_pool_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> (pool_q >= $past(pool_q)));
endmodule

// File: rtl/rcc_merge_ctl.sv
// Merge controller: decides which lines form a completion, keeps the group
// header fields, waits for credits and steps the payload beats out.
// Assumes comb_en and mps_sel change only while no group is held.
module rcc_merge_ctl
    import rcc_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int LADDR_W = 26,
    parameter int DEPTH   = 64,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int MAX_BYTES = DEPTH * LINE_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               comb_en,
    input  logic [2:0]         mps_sel,
    input  logic               line_valid,
    output logic               line_ready,
    input  logic [TAG_W-1:0]   line_tag,
    input  logic [LADDR_W-1:0] line_addr,
    input  logic [5:0]         line_lo,
    input  logic [6:0]         line_bytes,
    input  logic [LEN_W-1:0]   line_remain,
    input  logic               line_last,
    input  logic               cred_enough,
    output logic               take,
    output logic [COST_W-1:0]  cost,
    output logic               st_wr_en,
    output logic [IDX_W-1:0]   st_wr_idx,
    output logic [IDX_W-1:0]   st_rd_idx,
    output logic               cpl_valid,
    output logic               cpl_sop,
    output logic               cpl_eop,
    output logic [TAG_W-1:0]   cpl_tag,
    output logic [LEN_W-1:0]   cpl_len,
    output logic [LEN_W-1:0]   cpl_byte_count,
    output logic [LOW_W-1:0]   cpl_lower_addr
);
    rcc_state_e         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   beat_q;
    logic [LEN_W-1:0]   bytes_q;
    logic [TAG_W-1:0]   tag_q;
    logic [LADDR_W-1:0] next_q;
    logic [LEN_W-1:0]   bc_q;
    logic [LOW_W-1:0]   la_q;

    logic [LEN_W-1:0] cap;
    logic             held;
    logic             contig;
    logic             fits;
    logic             pre_flush;
    logic             accept;
    logic [LEN_W-1:0] new_bytes;
    logic             close_now;

    // Effective cap: one line when merging is off, else the selected size
    // bounded by what the store can hold.
    always_comb begin
        if (!comb_en)                          cap = LEN_W'(LINE_BYTES);
        else if (cap_bytes(mps_sel) > LEN_W'(MAX_BYTES)) cap = LEN_W'(MAX_BYTES);
        else                                   cap = cap_bytes(mps_sel);
    end

    // Group membership and close decisions for the offered line.
    always_comb begin
        held      = (cnt_q != '0);
        contig    = (line_tag == tag_q) && (line_addr == next_q);
        fits      = ({1'b0, bytes_q} + (LEN_W+1)'(line_bytes)) <= {1'b0, cap};
        pre_flush = (state_q == ST_COLLECT) && line_valid && held && (!contig || !fits);
        line_ready = (state_q == ST_COLLECT) && !pre_flush;
        accept    = line_valid && line_ready;
        new_bytes = (held ? bytes_q : '0) + LEN_W'(line_bytes);
        close_now = accept && (line_last || !comb_en || (new_bytes >= cap)
                               || (cnt_q == CNT_W'(DEPTH - 1)));
    end

    assign cost      = cpl_cost(bytes_q);
    assign take      = (state_q == ST_WAIT) && cred_enough;
    assign st_wr_en  = accept;
    assign st_wr_idx = cnt_q[IDX_W-1:0];
    assign st_rd_idx = beat_q[IDX_W-1:0];

    assign cpl_valid      = (state_q == ST_SEND);
    assign cpl_sop        = cpl_valid && (beat_q == '0);
    assign cpl_eop        = cpl_valid && (beat_q == cnt_q - CNT_W'(1));
    assign cpl_tag        = tag_q;
    assign cpl_len        = bytes_q;
    assign cpl_byte_count = bc_q;
    assign cpl_lower_addr = la_q;

    // Group state and sequencing: collect, wait for credits, send beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COLLECT;
            cnt_q   <= '0;
            beat_q  <= '0;
            bytes_q <= '0;
            tag_q   <= '0;
            next_q  <= '0;
            bc_q    <= '0;
            la_q    <= '0;
        end else begin
            case (state_q)
                ST_COLLECT: begin
                    if (pre_flush) begin
                        state_q <= ST_WAIT;
                    end else if (accept) begin
                        if (!held) begin
                            tag_q <= line_tag;
                            bc_q  <= line_remain;
                            la_q  <= {line_addr[0], line_lo};
                        end
                        next_q  <= line_addr + LADDR_W'(1);
                        cnt_q   <= cnt_q + CNT_W'(1);
                        bytes_q <= new_bytes;
                        if (close_now) state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cred_enough) begin
                        state_q <= ST_SEND;
                        beat_q  <= '0;
                    end
                end
                ST_SEND: begin
                    if (cpl_eop) begin
                        state_q <= ST_COLLECT;
                        cnt_q   <= '0;
                        bytes_q <= '0;
                        beat_q  <= '0;
                    end else begin
                        beat_q <= beat_q + CNT_W'(1);
                    end
                end
                default: state_q <= ST_COLLECT;
            endcase
        end
    end

    // A completion never exceeds the configured cap.
    assert_len_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_sop |-> (cpl_len <= cap));
    // Without merging each completion is a single beat.
    assert_single_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_sop && !comb_en) |-> cpl_eop);
    // Beats of one completion follow each other without gaps.
    assert_beats_contig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_eop) |=> (cpl_valid && !cpl_sop));
    // The store is never written past its last slot.
    assert_no_store_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |-> (cnt_q < CNT_W'(DEPTH)));
    // The remaining count always covers the payload being sent.
    assert_bc_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_sop |-> (cpl_byte_count >= cpl_len));
endmodule

// File: rtl/rcc_coalescer.sv
// Read completion coalescer top: joins the merge controller, the line store
// and the credit pool. Assumes lines of one request arrive in address order.
module rcc_coalescer
    import rcc_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int LADDR_W = 26,
    parameter int CRED_W  = 12,
    parameter int MAX_PAYLOAD = 4096,
    localparam int DEPTH  = MAX_PAYLOAD / LINE_BYTES,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int DATA_W = LINE_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               comb_en,
    input  logic [2:0]         mps_sel,
    input  logic [CRED_W-1:0]  credit_ret,
    input  logic               line_valid,
    output logic               line_ready,
    input  logic [TAG_W-1:0]   line_tag,
    input  logic [LADDR_W-1:0] line_addr,
    input  logic [5:0]         line_lo,
    input  logic [6:0]         line_bytes,
    input  logic [LEN_W-1:0]   line_remain,
    input  logic               line_last,
    input  logic [DATA_W-1:0]  line_data,
    output logic               cpl_valid,
    output logic               cpl_sop,
    output logic               cpl_eop,
    output logic [TAG_W-1:0]   cpl_tag,
    output logic [LEN_W-1:0]   cpl_len,
    output logic [LEN_W-1:0]   cpl_byte_count,
    output logic [LOW_W-1:0]   cpl_lower_addr,
    output logic [DATA_W-1:0]  cpl_data
);
    logic              cred_enough;
    logic              take;
    logic [COST_W-1:0] cost;
    logic              st_wr_en;
    logic [IDX_W-1:0]  st_wr_idx;
    logic [IDX_W-1:0]  st_rd_idx;

    rcc_merge_ctl #(
        .TAG_W   (TAG_W),
        .LADDR_W (LADDR_W),
        .DEPTH   (DEPTH)
    ) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .comb_en        (comb_en),
        .mps_sel        (mps_sel),
        .line_valid     (line_valid),
        .line_ready     (line_ready),
        .line_tag       (line_tag),
        .line_addr      (line_addr),
        .line_lo        (line_lo),
        .line_bytes     (line_bytes),
        .line_remain    (line_remain),
        .line_last      (line_last),
        .cred_enough    (cred_enough),
        .take           (take),
        .cost           (cost),
        .st_wr_en       (st_wr_en),
        .st_wr_idx      (st_wr_idx),
        .st_rd_idx      (st_rd_idx),
        .cpl_valid      (cpl_valid),
        .cpl_sop        (cpl_sop),
        .cpl_eop        (cpl_eop),
        .cpl_tag        (cpl_tag),
        .cpl_len        (cpl_len),
        .cpl_byte_count (cpl_byte_count),
        .cpl_lower_addr (cpl_lower_addr)
    );

    rcc_line_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_data (line_data),
        .rd_idx  (st_rd_idx),
        .rd_data (cpl_data)
    );

    rcc_credit_pool #(
        .CRED_W (CRED_W),
        .COST_W (COST_W)
    ) u_pool (
        .clk    (clk),
        .rst_n  (rst_n),
        .ret    (credit_ret),
        .take   (take),
        .cost   (cost),
        .enough (cred_enough)
    );
endmodule

// File: tb/rcc_coalescer_bench.sv
// Scoreboard bench: tests push expected completions, the driver pushes each
// line's data, a monitor pops and compares as completions appear.
module rcc_coalescer_bench;
    localparam int TAG_W = 8;
    localparam int LADDR_W = 26;
    localparam int CRED_W = 12;

    typedef struct {
        string       req;
        int          tag;
        int          len;
        int          bc;
        int          la;
        int          nb;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic comb_en = 1'b0;
    logic [2:0] mps_sel = 3'd0;
    logic [CRED_W-1:0] credit_ret = '0;
    logic line_valid = 1'b0;
    logic line_ready;
    logic [TAG_W-1:0] line_tag = '0;
    logic [LADDR_W-1:0] line_addr = '0;
    logic [5:0] line_lo = '0;
    logic [6:0] line_bytes = '0;
    logic [12:0] line_remain = '0;
    logic line_last = 1'b0;
    logic [511:0] line_data = '0;
    logic cpl_valid, cpl_sop, cpl_eop;
    logic [TAG_W-1:0] cpl_tag;
    logic [12:0] cpl_len, cpl_byte_count;
    logic [6:0] cpl_lower_addr;
    logic [511:0] cpl_data;

    int n_checks = 0;
    int n_fail = 0;
    int cpl_seen = 0;
    exp_t exp_q[$];
    logic [511:0] beat_q[$];

    always #4 clk = ~clk;

    rcc_coalescer u_rcc_coalescer (
        .clk(clk), .rst_n(rst_n), .comb_en(comb_en), .mps_sel(mps_sel),
        .credit_ret(credit_ret), .line_valid(line_valid), .line_ready(line_ready),
        .line_tag(line_tag), .line_addr(line_addr), .line_lo(line_lo),
        .line_bytes(line_bytes), .line_remain(line_remain), .line_last(line_last),
        .line_data(line_data), .cpl_valid(cpl_valid), .cpl_sop(cpl_sop),
        .cpl_eop(cpl_eop), .cpl_tag(cpl_tag), .cpl_len(cpl_len),
        .cpl_byte_count(cpl_byte_count), .cpl_lower_addr(cpl_lower_addr),
        .cpl_data(cpl_data)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic logic [511:0] pat(input int tag, input int addr);
        return {16{tag[7:0], addr[23:0]}};
    endfunction

    task automatic expect_cpl(input string req, input int tag, input int len,
                              input int bc, input int la, input int nb);
        exp_t e;
        e.req = req; e.tag = tag; e.len = len; e.bc = bc; e.la = la; e.nb = nb;
        exp_q.push_back(e);
    endtask

    task automatic send_line(input int tag, input int addr, input int lo,
                             input int bytes, input int remain, input bit last);
        line_tag = TAG_W'(tag); line_addr = LADDR_W'(addr); line_lo = 6'(lo);
        line_bytes = 7'(bytes); line_remain = 13'(remain); line_last = last;
        line_data = pat(tag, addr);
        beat_q.push_back(pat(tag, addr));
        line_valid = 1'b1;
        #1;
        while (!line_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        line_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || cpl_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Monitor: compare headers on the first beat and data on every beat.
    exp_t cur;
    int beats = 0;
    always @(negedge clk) begin
        if (rst_n && cpl_valid) begin
            if (cpl_sop) begin
                beats = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected completion", int'(cpl_tag), -1);
                    cur.req = "R9"; cur.nb = 0;
                end else begin
                    cur = exp_q.pop_front();
                    check(int'(cpl_tag) == cur.tag, {cur.req, " R7 tag"}, int'(cpl_tag), cur.tag);
                    check(int'(cpl_len) == cur.len, {cur.req, " length"}, int'(cpl_len), cur.len);
                    check(int'(cpl_byte_count) == cur.bc, {cur.req, " R7 byte count"}, int'(cpl_byte_count), cur.bc);
                    check(int'(cpl_lower_addr) == cur.la, {cur.req, " R7 lower address"}, int'(cpl_lower_addr), cur.la);
                end
            end
            beats++;
            if (beat_q.size() == 0) begin
                check(1'b0, "R9 beat without line", int'(cpl_data[31:0]), -1);
            end else begin
                logic [511:0] d;
                d = beat_q.pop_front();
                check(cpl_data == d, "R9 beat data", int'(cpl_data[31:0]), int'(d[31:0]));
            end
            if (cpl_eop) begin
                check(beats == cur.nb, {cur.req, " R9 beat count"}, beats, cur.nb);
                cpl_seen++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset.
        check(cpl_valid == 1'b0, "R1 no completion after reset", int'(cpl_valid), 0);
        check(line_ready == 1'b1, "R1 ready after reset", int'(line_ready), 1);

        // R8 / R10: empty pool stalls a 64-byte completion (cost 5).
        expect_cpl("R8", 1, 64, 64, 0, 1);
        send_line(1, 'h10, 0, 64, 64, 1);
        repeat (20) @(negedge clk);
        check(cpl_seen == 0, "R8 stall with empty pool", cpl_seen, 0);
        check(line_ready == 1'b0, "R10 ready low while waiting", int'(line_ready), 0);
        credit_ret = 12'd4;
        @(negedge clk);
        credit_ret = 12'd0;
        repeat (10) @(negedge clk);
        check(cpl_seen == 0, "R8 stall one credit short", cpl_seen, 0);
        credit_ret = 12'd1;
        @(negedge clk);
        credit_ret = 12'd0;
        drain();
        check(cpl_seen == 1, "R8 sent once covered", cpl_seen, 1);
        credit_ret = 12'd8;

        // R2: merging off, one completion per line.
        expect_cpl("R2", 2, 48, 176, 'h50, 1);
        expect_cpl("R2", 2, 64, 128, 'h00, 1);
        expect_cpl("R2", 2, 64, 64, 'h40, 1);
        send_line(2, 'h21, 'h10, 48, 176, 0);
        send_line(2, 'h22, 0, 64, 128, 0);
        send_line(2, 'h23, 0, 64, 64, 1);
        drain();

        // R3: merging on, cap 256, three lines merged.
        comb_en = 1'b1; mps_sel = 3'd1;
        expect_cpl("R3", 3, 192, 192, 0, 3);
        send_line(3, 'h30, 0, 64, 192, 0);
        send_line(3, 'h31, 0, 64, 128, 0);
        send_line(3, 'h32, 0, 64, 64, 1);
        drain();

        // R4: cap 128, exact fill and pre-close on overflow.
        mps_sel = 3'd0;
        expect_cpl("R4", 4, 128, 320, 0, 2);
        expect_cpl("R4", 4, 128, 192, 0, 2);
        expect_cpl("R4", 4, 64, 64, 0, 1);
        for (int i = 0; i < 5; i++) send_line(4, 'h40 + i, 0, 64, 320 - 64*i, i == 4);
        drain();
        expect_cpl("R4", 5, 96, 160, 'h60, 2);
        expect_cpl("R4", 5, 64, 64, 'h40, 1);
        send_line(5, 'h51, 'h20, 32, 160, 0);
        send_line(5, 'h52, 0, 64, 128, 0);
        send_line(5, 'h53, 0, 64, 64, 1);
        drain();

        // R5: small read across two lines gives one completion.
        mps_sel = 3'd1;
        expect_cpl("R5", 6, 16, 16, 'h78, 2);
        send_line(6, 'h61, 'h38, 8, 16, 0);
        send_line(6, 'h62, 0, 8, 8, 1);
        drain();

        // R6: tag change and address gap close the held group.
        mps_sel = 3'd2;
        expect_cpl("R6", 7, 64, 256, 0, 1);
        expect_cpl("R6", 8, 64, 64, 'h40, 1);
        send_line(7, 'h70, 0, 64, 256, 0);
        send_line(8, 'h71, 0, 64, 64, 1);
        drain();
        expect_cpl("R6", 9, 64, 192, 0, 1);
        expect_cpl("R6", 9, 128, 128, 0, 2);
        send_line(9, 'h80, 0, 64, 192, 0);
        send_line(9, 'h82, 0, 64, 128, 0);
        send_line(9, 'h83, 0, 64, 64, 1);
        drain();

        // R4: cap 512 with nine lines.
        expect_cpl("R4", 11, 512, 576, 0, 8);
        expect_cpl("R4", 11, 64, 64, 0, 1);
        for (int i = 0; i < 9; i++) send_line(11, 'h200 + i, 0, 64, 576 - 64*i, i == 8);
        drain();

        // R4: code 7 clamps to 4096; 65 lines give 4096 + 64.
        mps_sel = 3'd7;
        expect_cpl("R4", 10, 4096, 4160, 0, 64);
        expect_cpl("R4", 10, 64, 64, 0, 1);
        for (int i = 0; i < 65; i++) send_line(10, 'h1000 + i, 0, 64, 4160 - 64*i, i == 64);
        drain();

        check(exp_q.size() == 0, "R9 all completions seen", exp_q.size(), 0);
        check(beat_q.size() == 0, "R9 all beats seen", beat_q.size(), 0);
        finish_run();
    end
endmodule